// File: doc/BRIEF.md
# Wide-to-Narrow Memory-Mapped Bus Adapter

This block sits between a 32-bit memory-mapped master and a 16-bit memory-mapped slave. Each master read or write carries four byte enables. The adapter breaks the access into at most two halfword transfers at adjacent slave addresses. The slave address is twice the master word address plus the half index. Half 0 covers byte lanes 0-1 and half 1 covers byte lanes 2-3. When the access is a read, the adapter merges the returned halfwords into one 32-bit result. The master sees wait-request held high until the last slave transfer has finished.

A `slave_kind` input selects how the slave is driven. In byte-enable style, only the halves that have enabled bytes are visited, and their byte-enable pair is forwarded. In native style, the slave has no byte enables, so each visited half is written whole and any byte the master did not enable is written as zero. The third style is a legacy native setting. It touches only the low halfword and does not mask its data. The upper half is discarded and no second transfer takes place.

Both sides follow a simple wait-request protocol. A strobe is accepted in any cycle where it is high and the slave's wait-request is low. Read data from the slave is taken in that same cycle. The master must hold its request, address, data, byte enables and `slave_kind` until it sees its own wait-request go low.

Top module: `wide_narrow_bridge`

## Requirements
- R1: With `slave_kind` = 0 (byte-enable style) and `m_be` = 4'b1111, the adapter makes two slave transfers. The first is to address 2*W with `s_be` = 2'b11 and the low halfword. The second is to address 2*W+1 with the high halfword. W is `m_addr[31:2]`.
- R2: With `slave_kind` = 0, a half is visited only when its byte-enable pair (`m_be[1:0]` for half 0, `m_be[3:2]` for half 1) is nonzero, and `s_be` equals that pair. With `m_be` = 4'b0000, the access completes without any slave transfer.
- R3: A read returns the halfword from address 2*W in `m_rdata[15:0]` and the halfword from 2*W+1 in `m_rdata[31:16]`. A half that was not read returns zero.
- R4: With `slave_kind` = 1 (native), a half is visited when any byte in it is enabled, and `s_be` is always 2'b11. Each byte that is not enabled is written as 0x00. Two byte writes to one halfword therefore leave only the second byte's value.
- R5: With `slave_kind` = 2 (legacy native), every access is exactly one transfer to address 2*W with `s_be` = 2'b11 and `s_wdata` = `m_wdata[15:0]` unmasked. A read returns zero in `m_rdata[31:16]`.
- R6: `slave_kind` = 3 behaves exactly as native (value 1).
- R7: `m_waitreq` is low for exactly one cycle per access, and `m_rdata` is valid in that cycle. When the slave does not stall, `m_waitreq` goes low N+1 cycles after the request is first sampled, where N is the number of slave transfers. Each slave stall cycle adds one cycle.
- R8: While a slave strobe is held off by `s_waitreq`, `s_addr`, `s_be`, `s_wdata` and the strobe stay unchanged.
- R9: After reset, including a reset in the middle of an access, `s_read` and `s_write` are low and `m_waitreq` is high until a new request is served.
- R10: `s_read` and `s_write` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slave_kind | input | 2 | 0 byte-enable slave, 1 or 3 native slave, 2 legacy native |
| m_addr | input | 32 | Master byte address (word aligned) |
| m_read | input | 1 | Master read request |
| m_write | input | 1 | Master write request |
| m_be | input | 4 | Master byte enables |
| m_wdata | input | 32 | Master write data |
| m_rdata | output | 32 | Gathered read data, valid while `m_waitreq` is low |
| m_waitreq | output | 1 | Stall to the master; low for one cycle when the access is done |
| s_addr | output | 32 | Slave halfword address |
| s_read | output | 1 | Slave read strobe |
| s_write | output | 1 | Slave write strobe |
| s_be | output | 2 | Slave byte enables |
| s_wdata | output | 16 | Slave write data |
| s_rdata | input | 16 | Slave read data |
| s_waitreq | input | 1 | Slave stall |

## Verification
A wrong sequencer state shows up at the ports within one or two cycles. A missing or extra slave transfer changes the halfword count recorded by the bench model. It also shifts the cycle in which `m_waitreq` drops. A wrong half pointer writes the neighbouring slave address, and the memory readback exposes that. A gather register that was not cleared shows stale upper or lower bits on the next partial read. Reset in the middle of an access must drop the strobes on the first edge, and the following access must complete with its exact cycle count.

// File: rtl/bridge_pkg.sv
// Package: shared constants and types for the wide-to-narrow adapter.
// Assumes a master data path of two slave halfwords.
package bridge_pkg;

    localparam int HALF_W   = 16;
    localparam int HALVES   = 2;
    localparam int WIDE_W   = HALF_W * HALVES;
    localparam int HBE_W    = HALF_W / 8;
    localparam int WBE_W    = WIDE_W / 8;

    typedef enum logic [1:0] {
        KIND_BYTE_EN = 2'd0,
        KIND_NATIVE  = 2'd1,
        KIND_LEGACY  = 2'd2,
        KIND_NATIVE2 = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_RESP  = 2'd2
    } state_e;

    typedef struct packed {
        logic [HBE_W-1:0]  be;
        logic [HALF_W-1:0] data;
    } half_t;

endpackage

// File: rtl/bridge_planner.sv
// Module: bridge_planner
// Purpose: from the master byte enables, write data and slave kind, decide
// which halves need a slave transfer and what byte enables and data each
// half carries. Purely combinational.
// Assumes: the master holds its inputs stable for the whole access.
module bridge_planner
    import bridge_pkg::*;
(
    input  logic [1:0]        kind,
    input  logic [WBE_W-1:0]  be,
    input  logic [WIDE_W-1:0] wdata,
    output logic [HALVES-1:0] need,
    output half_t             plan [HALVES]
);

    logic legacy;
    logic with_be;

    // decode slave style
    always_comb begin
        legacy  = (kind == KIND_LEGACY);
        with_be = (kind == KIND_BYTE_EN);
    end

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        logic [HBE_W-1:0]  pair;
        logic [HALF_W-1:0] raw;
        logic [HALF_W-1:0] masked;

        // slice this half out of the wide bus
        always_comb begin
            pair = be[h*HBE_W +: HBE_W];
            raw  = wdata[h*HALF_W +: HALF_W];
            for (int b = 0; b < HBE_W; b++) begin
                masked[b*8 +: 8] = pair[b] ? raw[b*8 +: 8] : 8'h00;
            end
        end

        // choose transfer need, byte enables and data per slave style
        always_comb begin
            if (legacy) begin
                need[h]      = (h == 0);
                plan[h].be   = '1;
                plan[h].data = raw;
            end else if (with_be) begin
                need[h]      = |pair;
                plan[h].be   = pair;
                plan[h].data = raw;
            end else begin
                need[h]      = |pair;
                plan[h].be   = '1;
                plan[h].data = masked;
            end
        end
    end

endmodule

// File: rtl/bridge_seq.sv
// Module: bridge_seq
// Purpose: sequence one or two slave transfers for a master access, honour
// slave stalls, gather read halves and release the master for one cycle.
// Assumes: the master request stays high until m_waitreq is seen low.
module bridge_seq
    import bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              is_wr,
    input  logic [HALVES-1:0] need,
    input  logic              s_waitreq,
    input  logic [HALF_W-1:0] s_rdata,
    output logic              s_read,
    output logic              s_write,
    output logic              half_q,
    output logic              m_waitreq,
    output logic [WIDE_W-1:0] m_rdata
);

    state_e            state;
    logic              wr_q;
    logic [WIDE_W-1:0] gather_q;
    logic              accept;

    // a slave transfer completes this cycle
    always_comb begin
        accept = (state == ST_ISSUE) && !s_waitreq;
    end

    // state, half pointer, direction and gather register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            half_q   <= 1'b0;
            wr_q     <= 1'b0;
            gather_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req) begin
                        gather_q <= '0;
                        wr_q     <= is_wr;
                        half_q   <= !need[0];
                        state    <= (|need) ? ST_ISSUE : ST_RESP;
                    end
                end
                ST_ISSUE: begin
                    if (accept) begin
                        if (!wr_q) begin
                            gather_q[half_q*HALF_W +: HALF_W] <= s_rdata;
                        end
                        if (!half_q && need[1]) begin
                            half_q <= 1'b1;
                        end else begin
                            state <= ST_RESP;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // drive strobes and the master handshake from the state
    always_comb begin
        s_read    = (state == ST_ISSUE) && !wr_q;
        s_write   = (state == ST_ISSUE) && wr_q;
        m_waitreq = (state != ST_RESP);
        m_rdata   = gather_q;
    end

    assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_read && s_write));

    // R7: release lasts one cycle only
    assert_single_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !m_waitreq |=> m_waitreq);

    // R9: reset leaves no strobe behind
    assert_reset_idle_R9: assert property (@(posedge clk)
        !rst_n |=> (!s_read && !s_write && m_waitreq));

endmodule

// File: rtl/wide_narrow_bridge.sv
// Module: wide_narrow_bridge
// Purpose: adapt a 32-bit master with byte enables to a 16-bit slave that
// either has byte enables or is native (whole-halfword) style.
// Assumes: word-aligned master addresses; slave_kind stable during an access.
module wide_narrow_bridge
    import bridge_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        slave_kind,
    input  logic [ADDR_W-1:0] m_addr,
    input  logic              m_read,
    input  logic              m_write,
    input  logic [3:0]        m_be,
    input  logic [31:0]       m_wdata,
    output logic [31:0]       m_rdata,
    output logic              m_waitreq,
    output logic [ADDR_W-1:0] s_addr,
    output logic              s_read,
    output logic              s_write,
    output logic [1:0]        s_be,
    output logic [15:0]       s_wdata,
    input  logic [15:0]       s_rdata,
    input  logic              s_waitreq
);

    localparam int WORD_LSB = $clog2(WBE_W);

    logic [HALVES-1:0] need;
    half_t             plan [HALVES];
    logic              half_q;

    bridge_planner u_planner (
        .kind  (slave_kind),
        .be    (m_be),
        .wdata (m_wdata),
        .need  (need),
        .plan  (plan)
    );

    bridge_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (m_read || m_write),
        .is_wr     (m_write),
        .need      (need),
        .s_waitreq (s_waitreq),
        .s_rdata   (s_rdata),
        .s_read    (s_read),
        .s_write   (s_write),
        .half_q    (half_q),
        .m_waitreq (m_waitreq),
        .m_rdata   (m_rdata)
    );

    // form the slave halfword address and select the current half's plan
    always_comb begin
        s_addr  = {1'b0, m_addr[ADDR_W-1:WORD_LSB], half_q};
        s_be    = plan[half_q].be;
        s_wdata = plan[half_q].data;
    end

    // R8: a stalled transfer is held unchanged
    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_read || s_write) && s_waitreq) |=>
            ($stable(s_addr) && $stable(s_be) && $stable(s_wdata)
             && $stable(s_read) && $stable(s_write)));

    assert_native_full_be_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((slave_kind == KIND_NATIVE || slave_kind == KIND_NATIVE2)
         && (s_read || s_write)) |-> (s_be == 2'b11));

    assert_be_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((slave_kind == KIND_BYTE_EN) && (s_read || s_write)) |-> (s_be != 2'b00));

    assert_legacy_low_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((slave_kind == KIND_LEGACY) && (s_read || s_write)) |-> (!s_addr[0] && s_be == 2'b11));

endmodule

// File: tb/test_wide_narrow_bridge.sv
module test_wide_narrow_bridge;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  slave_kind = 2'd0;
    logic [31:0] m_addr = '0;
    logic        m_read = 1'b0;
    logic        m_write = 1'b0;
    logic [3:0]  m_be = '0;
    logic [31:0] m_wdata = '0;
    logic [31:0] m_rdata;
    logic        m_waitreq;
    logic [31:0] s_addr;
    logic        s_read;
    logic        s_write;
    logic [1:0]  s_be;
    logic [15:0] s_wdata;
    logic [15:0] s_rdata;
    logic        s_waitreq;

    int checks = 0;
    int errors = 0;
    int xfers = 0;
    int stall_cfg = 0;
    int stall_cnt = 0;
    int wd = 0;
    logic [15:0] mem [16];

    always #4 clk = ~clk;

    wide_narrow_bridge i_wide_narrow_bridge (
        .clk(clk), .rst_n(rst_n), .slave_kind(slave_kind),
        .m_addr(m_addr), .m_read(m_read), .m_write(m_write), .m_be(m_be),
        .m_wdata(m_wdata), .m_rdata(m_rdata), .m_waitreq(m_waitreq),
        .s_addr(s_addr), .s_read(s_read), .s_write(s_write), .s_be(s_be),
        .s_wdata(s_wdata), .s_rdata(s_rdata), .s_waitreq(s_waitreq)
    );

    // slave model: halfword memory with programmable stall per transfer
    assign s_waitreq = (s_read || s_write) && (stall_cnt < stall_cfg);
    assign s_rdata   = mem[s_addr[3:0]];

    always @(posedge clk) begin
        if (!rst_n) begin
            stall_cnt <= 0;
            for (int i = 0; i < 16; i++) mem[i] <= 16'hC050 + 16'h0101 * i[15:0];
        end else if (s_read || s_write) begin
            if (s_waitreq) begin
                stall_cnt <= stall_cnt + 1;
            end else begin
                stall_cnt <= 0;
                xfers <= xfers + 1;
                if (s_write) begin
                    if (s_be[0]) mem[s_addr[3:0]][7:0]  <= s_wdata[7:0];
                    if (s_be[1]) mem[s_addr[3:0]][15:8] <= s_wdata[15:8];
                end
            end
        end
    end

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 50000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // one master access; returns read data, cycles to release and slave transfers
    task automatic access(input logic [1:0] kind, input logic wr, input logic [2:0] word,
                          input logic [3:0] be, input logic [31:0] wd_in,
                          output logic [31:0] rd, output int cyc, output int n);
        int x0;
        @(negedge clk);
        x0 = xfers;
        slave_kind = kind; m_addr = {27'd0, word, 2'b00}; m_be = be; m_wdata = wd_in;
        m_write = wr; m_read = !wr;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (m_waitreq && cyc < 1000);
        rd = m_rdata;
        m_read = 1'b0; m_write = 1'b0;
        @(negedge clk);
        n = xfers - x0;
    endtask

    typedef struct packed {
        logic [3:0]  req;
        logic [1:0]  kind;
        logic        wr;
        logic [2:0]  word;
        logic [3:0]  be;
        logic [31:0] wdata;
        logic [1:0]  n;
        logic [15:0] lo;
        logic [15:0] hi;
    } vec_t;

    // for writes lo/hi are the slave halfwords afterwards; for reads, m_rdata halves
    localparam vec_t VEC [0:14] = '{
        '{4'd1, 2'd0, 1'b1, 3'd0, 4'hF, 32'h12345678, 2'd2, 16'h5678, 16'h1234}, // R1
        '{4'd3, 2'd0, 1'b0, 3'd0, 4'hF, 32'h0,        2'd2, 16'h5678, 16'h1234}, // R3
        '{4'd2, 2'd0, 1'b1, 3'd1, 4'h1, 32'hAABBCCDD, 2'd1, 16'hC2DD, 16'hC353}, // R2
        '{4'd2, 2'd0, 1'b1, 3'd1, 4'h8, 32'h11223344, 2'd1, 16'hC2DD, 16'h1153}, // R2
        '{4'd2, 2'd0, 1'b1, 3'd2, 4'h6, 32'h01020304, 2'd2, 16'h0354, 16'hC502}, // R2
        '{4'd3, 2'd0, 1'b0, 3'd3, 4'hC, 32'h0,        2'd1, 16'h0000, 16'hC757}, // R3
        '{4'd4, 2'd1, 1'b1, 3'd4, 4'h1, 32'h000000AB, 2'd1, 16'h00AB, 16'hC959}, // R4
        '{4'd4, 2'd1, 1'b1, 3'd4, 4'h2, 32'h0000CD00, 2'd1, 16'hCD00, 16'hC959}, // R4
        '{4'd4, 2'd1, 1'b1, 3'd5, 4'h4, 32'h55EF6677, 2'd1, 16'hCA5A, 16'h00EF}, // R4
        '{4'd3, 2'd1, 1'b0, 3'd5, 4'hF, 32'h0,        2'd2, 16'hCA5A, 16'h00EF}, // R3
        '{4'd5, 2'd2, 1'b1, 3'd6, 4'hF, 32'h99997777, 2'd1, 16'h7777, 16'hCD5D}, // R5
        '{4'd5, 2'd2, 1'b1, 3'd6, 4'h2, 32'h00003311, 2'd1, 16'h3311, 16'hCD5D}, // R5
        '{4'd5, 2'd2, 1'b0, 3'd6, 4'hF, 32'h0,        2'd1, 16'h3311, 16'h0000}, // R5
        '{4'd2, 2'd0, 1'b1, 3'd7, 4'h0, 32'hFFFFFFFF, 2'd0, 16'hCE5E, 16'hCF5F}, // R2
        '{4'd6, 2'd3, 1'b1, 3'd7, 4'h4, 32'h12345678, 2'd1, 16'hCE5E, 16'h0034}  // R6
    };

    initial begin
        logic [31:0] rd;
        int cyc, n;
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 reset s_read",    {31'd0, s_read},    32'd0);
        check("R9 reset s_write",   {31'd0, s_write},   32'd0);
        check("R9 reset m_waitreq", {31'd0, m_waitreq}, 32'd1);
        rst_n = 1'b1;

        for (int v = 0; v < 15; v++) begin
            string tag;
            tag = $sformatf("vec %0d R%0d", v, VEC[v].req);
            access(VEC[v].kind, VEC[v].wr, VEC[v].word, VEC[v].be, VEC[v].wdata, rd, cyc, n);
            check({tag, " transfers"}, n, {30'd0, VEC[v].n});
            // R7: release after N+1 cycles without stalls
            check({tag, " R7 cycles"}, cyc, VEC[v].n + 1);
            if (VEC[v].wr) begin
                check({tag, " low half"},  {16'd0, mem[{VEC[v].word, 1'b0}]}, {16'd0, VEC[v].lo});
                check({tag, " high half"}, {16'd0, mem[{VEC[v].word, 1'b1}]}, {16'd0, VEC[v].hi});
            end else begin
                check({tag, " rdata"}, rd, {VEC[v].hi, VEC[v].lo});
            end
        end

        // R7 and R8: stalled full-word write and read, 3 stall cycles per transfer
        stall_cfg = 3;
        access(2'd0, 1'b1, 3'd3, 4'hF, 32'hBEEF0F0F, rd, cyc, n);
        check("R7 stalled write cycles", cyc, 2 * 4 + 1);
        check("R8 stalled write low",  {16'd0, mem[6]}, 32'h00000F0F);
        check("R8 stalled write high", {16'd0, mem[7]}, 32'h0000BEEF);
        access(2'd0, 1'b0, 3'd3, 4'hF, 32'h0, rd, cyc, n);
        check("R3 stalled read gather", rd, 32'hBEEF0F0F);
        check("R7 stalled read cycles", cyc, 9);

        // R9: reset in the middle of a stalled access
        stall_cfg = 100;
        @(negedge clk);
        slave_kind = 2'd0; m_addr = 32'h0; m_be = 4'hF; m_write = 1'b1; m_read = 1'b0;
        m_wdata = 32'h0;
        repeat (4) @(negedge clk);
        check("R9 strobe active before reset", {31'd0, s_write}, 32'd1);
        rst_n = 1'b0; m_write = 1'b0;
        @(negedge clk);
        check("R9 s_write after reset", {31'd0, s_write}, 32'd0);
        check("R9 m_waitreq after reset", {31'd0, m_waitreq}, 32'd1);
        stall_cfg = 0;
        rst_n = 1'b1;
        access(2'd0, 1'b0, 3'd0, 4'hF, 32'h0, rd, cyc, n);
        check("R9 access after reset rdata", rd, 32'hC151C050);
        check("R9 access after reset cycles", cyc, 3);

        finish_run();
    end

endmodule